// File: doc/BRIEF.md
# Echo-Checking Half-Duplex UART Transmitter

This block drives frames onto a shared single-wire serial bus and watches its own echo. A frame is a low start bit, nine data bits sent least significant bit first, and a high stop bit. The frame advances one bit per pulse of an external bit-clock enable. Baud generation and the receiver live elsewhere.

While a frame is on the line, the block compares the level it drives with the level read back from the bus. A difference raises a sticky collision flag. Software clears the flag with a one-cycle pulse. Three configuration inputs set the behaviour:

- **Sampling instant:** the comparison happens either on the bit clock or on an external one-shot strobe.
- **Auto-disable:** a collision can also clear the transmit-enable bit.
- **Start condition:** a frame starts either on the next bit-clock pulse or on an edge seen on the receive line.

A polarity input inverts both pins, so all decisions are made on logical levels.

Top module: `echo_uart_tx`

## Requirements
- R1: The frame is 11 bits in logical levels: a start bit of 0, then data bits 0 through 8 with bit 0 first, then a stop bit of 1. Each bit is replaced at the bit_tick_i pulse that ends it. The idle line is logical 1.
- R2: With edge_start_i=0, a word held while tx_en_o=1 starts at the first bit_tick_i. The start bit and busy_o=1 are visible the cycle after that pulse, and not before it.
- R3: With cmp_sel_i=0, while busy_o=1, each bit_tick_i compares the driven logical bit with the logical rxd_i level. A mismatch sets coll_flag_o on the next cycle.
- R4: With cmp_sel_i=1, the comparison is made only on cmp_strobe_i pulses, and bit_tick_i pulses make no comparison.
- R5: coll_flag_o stays set until a coll_clr_i pulse. When a clear and a mismatch happen in the same cycle, the clear wins.
- R6: The physical level of txd_o is the logical level XOR line_inv_i. The logical level of rxd_i is the physical level XOR line_inv_i.
- R7: With auto_dis_i=1, a mismatch clears tx_en_o in the same cycle that it sets the flag. This clear has priority over an en_wr_i write in that cycle. With auto_dis_i=0, tx_en_o is unchanged.
- R8: If tx_en_o is 0 at a bit_tick_i during a frame, the line returns to idle and busy_o falls on the next cycle. The rest of the frame is discarded.
- R9: With edge_start_i=1, a logical falling edge on rxd_i starts a held word while tx_en_o=1. For line_inv_i=0 this is a physical falling edge; for line_inv_i=1 it is a physical rising edge. The start bit appears on the next cycle, and bit_tick_i does not start a frame in this mode.
- R10: An rxd_i edge while tx_en_o=0 does not start a frame. Comparisons made while busy_o=0 never set the flag.
- R11: load_i is accepted only when no word is held and no frame is being sent. Loads at other times are ignored.
- R12: en_wr_i writes en_wdata_i into tx_en_o. Reset gives tx_en_o=0, coll_flag_o=0, busy_o=0 and an idle line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| cmp_strobe_i | input | 1 | External one-shot sampling strobe |
| cmp_sel_i | input | 1 | 0: compare on bit_tick_i; 1: compare on cmp_strobe_i |
| auto_dis_i | input | 1 | A collision clears the transmit enable |
| edge_start_i | input | 1 | 0: start on bit_tick_i; 1: start on an rxd_i edge |
| line_inv_i | input | 1 | Inverts the polarity of both pins |
| en_wr_i | input | 1 | Write strobe for the transmit-enable bit |
| en_wdata_i | input | 1 | Value written into the transmit-enable bit |
| load_i | input | 1 | Load a word into the holding register |
| data_i | input | 9 | Word to send |
| rxd_i | input | 1 | Read-back level of the bus |
| coll_clr_i | input | 1 | Clears the collision flag |
| txd_o | output | 1 | Driven line level |
| busy_o | output | 1 | A frame is being driven |
| tx_en_o | output | 1 | Transmit-enable bit |
| coll_flag_o | output | 1 | Sticky collision flag |

## Verification
Every result is due one clock after the input edge that causes it:

- **Frame bits and start:** a start pulse or bit_tick_i yields the next frame bit and busy_o one cycle later.
- **Collision:** a comparison event sets coll_flag_o, and clears tx_en_o under auto-disable, one cycle later.
- **Abort:** the abort takes effect one cycle after the first bit_tick_i that follows the clear of tx_en_o.

The bench drives each stimulus just after a falling edge and samples at the next falling edge, exactly one rising edge later. Negative cases check that nothing changed at that same point: no start before the tick, no flag from a tick in strobe mode, no flag while idle, and no frame from an edge while disabled.

// File: rtl/ectx_pkg.sv
package ectx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_SEND  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ectx_rx_edge.sv
module ectx_rx_edge (
  input  logic clk,
  input  logic rst,
  input  logic rxd_i,
  input  logic line_inv_i,
  output logic rx_log_o,
  output logic rx_fall_o
);
  logic rx_q;

  always_ff @(posedge clk) begin
    rx_q <= rxd_i;
  end

  // logical levels: a physical rise under inversion reads as a logical fall
  assign rx_log_o  = rxd_i ^ line_inv_i;
  assign rx_fall_o = !rst && (rx_q ^ line_inv_i) && !rx_log_o;
endmodule

// File: rtl/ectx_frame_seq.sv
module ectx_frame_seq
  import ectx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick_i,
  input  logic              rx_fall_i,
  input  logic              edge_start_i,
  input  logic              tx_en_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              line_inv_i,
  output logic              cur_bit_o,
  output logic              sending_o,
  output logic              txd_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  tx_state_e            state_q, state_d;
  logic [DATA_W-1:0]    hold_q, hold_d;
  logic [FRAME_W-1:0]   shreg_q, shreg_d;
  logic [IDX_W-1:0]     cnt_q, cnt_d;
  logic                 txd_q;
  logic                 start_go;

  always_comb begin
    state_d  = state_q;
    hold_d   = hold_q;
    shreg_d  = shreg_q;
    cnt_d    = cnt_q;
    start_go = (state_q == ST_READY) && tx_en_i &&
               (edge_start_i ? rx_fall_i : bit_tick_i);
    unique case (state_q)
      ST_IDLE: begin
        if (load_i) begin
          hold_d  = data_i;
          state_d = ST_READY;
        end
      end
      ST_READY: begin
        if (start_go) begin
          shreg_d = {1'b1, hold_q, 1'b0};
          cnt_d   = '0;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (bit_tick_i) begin
          if (!tx_en_i || cnt_q == LAST_IDX) begin
            shreg_d = '1;
            state_d = ST_IDLE;
          end else begin
            shreg_d = {1'b1, shreg_q[FRAME_W-1:1]};
            cnt_d   = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      shreg_q <= '1;
      cnt_q   <= '0;
      txd_q   <= ~line_inv_i;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      txd_q   <= shreg_d[0] ^ line_inv_i;
    end
  end

  assign cur_bit_o = shreg_q[0];
  assign sending_o = (state_q == ST_SEND);
  assign txd_o     = txd_q;

  // R1: every frame opens with a logical 0
  a_r1_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sending_o) |-> !cur_bit_o);
  // R2: tick-start mode launches on the tick
  a_r2_tick_start: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READY && tx_en_i && !edge_start_i && bit_tick_i) |=> sending_o);
  // R9: edge-start mode launches on the logical fall
  a_r9_edge_start: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READY && tx_en_i && edge_start_i && rx_fall_i) |=> (sending_o && !cur_bit_o));
  // R8: disabled at a bit boundary ends the frame
  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    (sending_o && bit_tick_i && !tx_en_i) |=> (!sending_o && cur_bit_o));
endmodule

// File: rtl/ectx_coll_mon.sv
module ectx_coll_mon (
  input  logic clk,
  input  logic rst,
  input  logic sending_i,
  input  logic cur_bit_i,
  input  logic rx_log_i,
  input  logic cmp_sel_i,
  input  logic bit_tick_i,
  input  logic cmp_strobe_i,
  input  logic auto_dis_i,
  input  logic coll_clr_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  output logic coll_flag_o,
  output logic tx_en_o
);
  logic flag_q, en_q;
  logic sample, mismatch;

  assign sample   = sending_i && (cmp_sel_i ? cmp_strobe_i : bit_tick_i);
  assign mismatch = sample && (cur_bit_i != rx_log_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (coll_clr_i)    flag_q <= 1'b0;
      else if (mismatch) flag_q <= 1'b1;
      if (mismatch && auto_dis_i) en_q <= 1'b0;
      else if (en_wr_i)           en_q <= en_wdata_i;
    end
  end

  assign coll_flag_o = flag_q;
  assign tx_en_o     = en_q;

  // R5: clear beats any set in the same cycle
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
    coll_clr_i |=> !coll_flag_o);
  // R3: a sampled difference raises the flag
  a_r3_flag_set: assert property (@(posedge clk) disable iff (rst)
    (sending_i && !cmp_sel_i && bit_tick_i && (cur_bit_i != rx_log_i) && !coll_clr_i) |=> coll_flag_o);
  // R7: auto-disable drops the enable
  a_r7_auto_off: assert property (@(posedge clk) disable iff (rst)
    (mismatch && auto_dis_i) |=> !tx_en_o);
  // R10: nothing changes the flag while the line is idle, apart from a clear
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!sending_i && !coll_clr_i) |=> $stable(coll_flag_o));
endmodule

// File: rtl/echo_uart_tx.sv
module echo_uart_tx #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick_i,
  input  logic              cmp_strobe_i,
  input  logic              cmp_sel_i,
  input  logic              auto_dis_i,
  input  logic              edge_start_i,
  input  logic              line_inv_i,
  input  logic              en_wr_i,
  input  logic              en_wdata_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rxd_i,
  input  logic              coll_clr_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              tx_en_o,
  output logic              coll_flag_o
);
  logic rx_log, rx_fall, cur_bit, sending;

  ectx_rx_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .rxd_i     (rxd_i),
    .line_inv_i(line_inv_i),
    .rx_log_o  (rx_log),
    .rx_fall_o (rx_fall)
  );

  ectx_frame_seq #(.DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .bit_tick_i  (bit_tick_i),
    .rx_fall_i   (rx_fall),
    .edge_start_i(edge_start_i),
    .tx_en_i     (tx_en_o),
    .load_i      (load_i),
    .data_i      (data_i),
    .line_inv_i  (line_inv_i),
    .cur_bit_o   (cur_bit),
    .sending_o   (sending),
    .txd_o       (txd_o)
  );

  ectx_coll_mon u_mon (
    .clk         (clk),
    .rst         (rst),
    .sending_i   (sending),
    .cur_bit_i   (cur_bit),
    .rx_log_i    (rx_log),
    .cmp_sel_i   (cmp_sel_i),
    .bit_tick_i  (bit_tick_i),
    .cmp_strobe_i(cmp_strobe_i),
    .auto_dis_i  (auto_dis_i),
    .coll_clr_i  (coll_clr_i),
    .en_wr_i     (en_wr_i),
    .en_wdata_i  (en_wdata_i),
    .coll_flag_o (coll_flag_o),
    .tx_en_o     (tx_en_o)
  );

  assign busy_o = sending;
endmodule

// File: tb/echo_uart_tx_tb_top.sv
`timescale 1ns/1ps
module echo_uart_tx_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick_i = 0, cmp_strobe_i = 0, cmp_sel_i = 0, auto_dis_i = 0;
  logic edge_start_i = 0, line_inv_i = 0, en_wr_i = 0, en_wdata_i = 0;
  logic load_i = 0, coll_clr_i = 0;
  logic [8:0] data_i = '0;
  logic rx_ovr = 0, rx_drv = 1, rx_flip = 0;
  logic rxd_i, txd_o, busy_o, tx_en_o, coll_flag_o;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  assign rxd_i = rx_ovr ? rx_drv : (txd_o ^ rx_flip);

  echo_uart_tx dut_i (
    .clk(clk), .rst(rst), .bit_tick_i(bit_tick_i), .cmp_strobe_i(cmp_strobe_i),
    .cmp_sel_i(cmp_sel_i), .auto_dis_i(auto_dis_i), .edge_start_i(edge_start_i),
    .line_inv_i(line_inv_i), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .load_i(load_i), .data_i(data_i), .rxd_i(rxd_i), .coll_clr_i(coll_clr_i),
    .txd_o(txd_o), .busy_o(busy_o), .tx_en_o(tx_en_o), .coll_flag_o(coll_flag_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic pulse_tick(); bit_tick_i = 1; step(); bit_tick_i = 0; endtask
  task automatic pulse_strobe(); cmp_strobe_i = 1; step(); cmp_strobe_i = 0; endtask
  task automatic pulse_clr(); coll_clr_i = 1; step(); coll_clr_i = 0; endtask
  task automatic write_en(input logic v);
    en_wr_i = 1; en_wdata_i = v; step(); en_wr_i = 0;
  endtask
  task automatic load_word(input logic [8:0] d);
    load_i = 1; data_i = d; step(); load_i = 0;
  endtask
  task automatic gap(); step(); step(); endtask

  function automatic logic frame_bit(input logic [8:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k == 10) return 1'b1;
    return d[k-1];
  endfunction

  task automatic drain();
    for (int k = 0; k < 12 && busy_o; k++) begin gap(); pulse_tick(); end
  endtask

  task automatic t_reset();
    chk("R12 reset txd idle", txd_o, 1'b1);
    chk("R12 reset busy", busy_o, 1'b0);
    chk("R12 reset tx_en", tx_en_o, 1'b0);
    chk("R12 reset flag", coll_flag_o, 1'b0);
  endtask

  // tick-start frame, clean echo, with a stray load mid-frame
  task automatic t_frame(input logic [8:0] d, input logic inv);
    line_inv_i = inv; gap();
    write_en(1'b1);
    chk("R12 enable write", tx_en_o, 1'b1);
    load_word(d);
    gap(); step();
    chk("R2 no start before tick", busy_o, 1'b0);
    chk("R6 idle physical level", txd_o, 1'b1 ^ inv);
    pulse_tick();
    chk("R2 busy after tick", busy_o, 1'b1);
    chk("R1 start bit", txd_o ^ inv, 1'b0);
    for (int k = 1; k <= 10; k++) begin
      gap();
      if (k == 5) load_word(~d);
      pulse_tick();
      chk("R1 frame bit", txd_o ^ inv, frame_bit(d, k));
      chk("R6 physical bit", txd_o, frame_bit(d, k) ^ inv);
    end
    gap(); pulse_tick();
    chk("R1 frame ends", busy_o, 1'b0);
    chk("R1 idle after stop", txd_o ^ inv, 1'b1);
    chk("R3 clean echo no flag", coll_flag_o, 1'b0);
    gap(); pulse_tick(); gap(); pulse_tick();
    chk("R11 mid-frame load ignored", busy_o, 1'b0);
  endtask

  task automatic t_coll_tick();
    cmp_sel_i = 0; auto_dis_i = 0; line_inv_i = 0;
    load_word(9'h0A5); pulse_tick(); gap(); pulse_tick(); gap();
    rx_flip = 1; step();
    chk("R3 no compare without tick", coll_flag_o, 1'b0);
    pulse_tick();
    chk("R3 flag on tick mismatch", coll_flag_o, 1'b1);
    chk("R7 enable kept without auto", tx_en_o, 1'b1);
    chk("R7 frame continues", busy_o, 1'b1);
    rx_flip = 0;
    drain();
    chk("R5 flag sticky", coll_flag_o, 1'b1);
    pulse_clr();
    chk("R5 clear", coll_flag_o, 1'b0);
  endtask

  task automatic t_coll_strobe();
    cmp_sel_i = 1; auto_dis_i = 0;
    load_word(9'h133); pulse_tick(); gap();
    rx_flip = 1; pulse_tick();
    chk("R4 tick ignored in strobe mode", coll_flag_o, 1'b0);
    pulse_strobe();
    chk("R4 flag on strobe", coll_flag_o, 1'b1);
    coll_clr_i = 1; cmp_strobe_i = 1; step(); coll_clr_i = 0; cmp_strobe_i = 0;
    chk("R5 clear wins over set", coll_flag_o, 1'b0);
    rx_flip = 0;
    drain();
    cmp_sel_i = 0;
  endtask

  task automatic t_auto();
    cmp_sel_i = 0; auto_dis_i = 1;
    load_word(9'h1FF); pulse_tick(); gap(); pulse_tick(); gap();
    rx_flip = 1; en_wr_i = 1; en_wdata_i = 1; pulse_tick(); en_wr_i = 0;
    chk("R7 auto clears enable", tx_en_o, 1'b0);
    chk("R3 flag with auto", coll_flag_o, 1'b1);
    rx_flip = 0; gap();
    chk("R8 busy held until boundary", busy_o, 1'b1);
    pulse_tick();
    chk("R8 aborted at boundary", busy_o, 1'b0);
    chk("R8 line idle after abort", txd_o, 1'b1);
    write_en(1'b1); gap(); pulse_tick();
    chk("R8 frame not resumed", busy_o, 1'b0);
    auto_dis_i = 0; pulse_clr();
  endtask

  task automatic t_idle();
    rx_flip = 1; cmp_sel_i = 0; pulse_tick();
    cmp_sel_i = 1; pulse_strobe();
    chk("R10 no compare while idle", coll_flag_o, 1'b0);
    rx_flip = 0; cmp_sel_i = 0; gap();
  endtask

  task automatic t_edge(input logic inv, input logic [8:0] d);
    edge_start_i = 1; line_inv_i = inv; rx_ovr = 1; rx_drv = ~inv; gap();
    write_en(1'b0);
    load_word(d);
    rx_drv = inv; gap();
    chk("R10 edge while disabled ignored", busy_o, 1'b0);
    rx_drv = ~inv; step();
    write_en(1'b1);
    pulse_tick();
    chk("R9 tick does not start", busy_o, 1'b0);
    rx_drv = inv; step();
    chk("R9 edge starts frame", busy_o, 1'b1);
    chk("R9 start bit", txd_o ^ inv, 1'b0);
    rx_ovr = 0;
    for (int k = 1; k <= 10; k++) begin
      gap(); pulse_tick();
      chk("R9 frame bit", txd_o ^ inv, frame_bit(d, k));
    end
    gap(); pulse_tick();
    chk("R9 frame ends", busy_o, 1'b0);
    chk("R9 no collision", coll_flag_o, 1'b0);
    edge_start_i = 0; line_inv_i = 0; rx_drv = 1; gap();
  endtask

  initial begin
    repeat (3) step();
    rst = 0; step();
    t_reset();
    t_frame(9'h1A5, 1'b0);
    t_frame(9'h0F3, 1'b1);
    line_inv_i = 0; gap();
    t_coll_tick();
    t_coll_strobe();
    t_auto();
    t_idle();
    t_edge(1'b0, 9'h156);
    t_edge(1'b1, 9'h0C9);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule